// File: doc/BRIEF.md
# Element Address Generator (linear and swizzled-tile layouts)

This block turns a two-dimensional element index into a 32-bit byte address for a surface in memory. Each request carries the index (x, y), a base address aligned to 2 KB and a packed format word that gives the row pitch in elements, the layout (row-major linear or a tiled layout with an XOR bit swizzle inside 2 KB tiles) and the element data format, which fixes the element size at 2, 4, 8 or 16 bytes.

When a request is marked as an input fetch and its layout code has the 2x2 flag set, one request becomes four output addresses, one for each corner of a 2x2 element quad. Each address carries a channel tag naming the register lane that should receive that element. Requests enter through a valid/ready handshake and addresses leave through a second valid/ready handshake. A data format code the block does not know is dropped and flagged instead of being translated.

Top module: `ltag_addr_gen`

## Requirements
- R1: After reset, out_valid and fmt_err are 0 and req_ready is 1.
- R2: The format word is decoded as follows. pitch = {req_fmt[12:2], 2'b00} elements. Layout = req_fmt[17:16]: 0 linear, 1 tiled, 2 linear with 2x2, 3 tiled with 2x2. Data format = req_fmt[26:24]: 0 gives 2 bytes per element, 1 and 2 give 4, 3 gives 8 and 4 gives 16.
- R3: req_base[10:0] has no effect on the address; only req_base[31:11] is used.
- R4: In linear layout with element size 2^s bytes, out_addr = y*(pitch >> (5-s))*32 + x*2^s + base, modulo 2^32.
- R5: In tiled layout the tile width is 2^w elements (w = 5 for 2- and 4-byte elements, 4 for 8- and 16-byte elements) and the tile height is 2^h rows (h = 5, 4, 4, 3 for 2, 4, 8, 16 bytes). out_addr[31:11] = (y>>h)*(pitch>>w) + (x>>w) + base[31:11].
- R6: Tiled out_addr[10:0], listed from bit 10 down, is {y4^x5, x4^y5, y3^x4, x3^y4, y2, x2, y1, y0, x1, x0, 0} for 2-byte elements; {y3^x5, x4^y4, y2^x4, x3^y3, y1, x2, y0, x1, x0, 0, 0} for 4-byte; {y3^x4, x3^y4, y2^x3, x2^y3, y1, x1, y0, x0, 0, 0, 0} for 8-byte; {y2^x4, x3^y3, y1^x3, x2^y2, y0, x1, x0, 0, 0, 0, 0} for 16-byte.
- R7: A 2x2 expansion produces, in this order, the addresses of (x+1, y), (x, y+1), (x+1, y+1) and (x, y), with out_chan 0, 1, 2 and 3. The coordinates wrap at 12 bits. A request that is not expanded produces one address with out_chan 0.
- R8: The 2x2 flag (req_fmt[17]) applies only when req_is_input is 1. Otherwise the request produces a single address for (x, y).
- R9: Once a request is accepted, req_ready stays 0 until its last address has been accepted on the output. It returns to 1 in the following cycle.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_addr and out_chan hold their values.
- R11: A request whose data format is above 4 is accepted and dropped. fmt_err pulses high for exactly the one cycle after acceptance, and out_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_x | input | 12 | Element column index |
| req_y | input | 12 | Element row index |
| req_base | input | 32 | Surface base; bits [10:0] ignored |
| req_fmt | input | 32 | Packed pitch, layout and data format |
| req_is_input | input | 1 | Request is an input-class fetch |
| out_valid | output | 1 | Address present |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | 32 | Byte address |
| out_chan | output | 2 | Destination channel of this address |
| fmt_err | output | 1 | One-cycle pulse for a reserved data format |

## Verification
The bench drives indices whose low bits carry distinct patterns into every element size and both layouts. A wrong bit slice, a missing XOR term or a wrong pitch shift then moves the address away from the value computed from the formulas. It sends a base with its low 11 bits set, which exposes a design that adds them. It expands quads at x = 4095, where a design that carries out of 12 bits or emits the corners out of order is caught. It also expands quads from a non-input request, where a design that ignores the class emits four addresses instead of one. It stalls the output mid-expansion and checks that the held address does not drift. It sends a reserved format code, which a faulty design would translate or fail to flag.

// File: rtl/ltag_pkg.sv
package ltag_pkg;
  localparam int IDX_W    = 12;
  localparam int ADDR_W   = 32;
  localparam int TILE_LOG = 11;
  localparam int PITCH_W  = 14;
  localparam int CHAN_W   = 2;
  localparam int HI_W     = ADDR_W - TILE_LOG;

  typedef struct packed {
    logic [IDX_W-1:0]   x;
    logic [IDX_W-1:0]   y;
    logic [HI_W-1:0]    base_hi;
    logic [PITCH_W-1:0] pitch;
    logic               tiled;
    logic [2:0]         lsz;    // log2 of bytes per element
    logic               quad;
  } ltag_req_t;
endpackage

// File: rtl/ltag_fmt_decode.sv
module ltag_fmt_decode
  import ltag_pkg::*;
(
  input  logic [IDX_W-1:0]  x,
  input  logic [IDX_W-1:0]  y,
  input  logic [ADDR_W-1:0] base,
  input  logic [31:0]       fmt,
  input  logic              is_input,
  output ltag_req_t         req,
  output logic              bad_fmt
);
  always_comb begin
    req.x       = x;
    req.y       = y;
    req.base_hi = base[ADDR_W-1:TILE_LOG];
    req.pitch   = {1'b0, fmt[12:2], 2'b00};
    req.tiled   = fmt[16];
    req.quad    = fmt[17] & is_input;
    bad_fmt     = 1'b0;
    case (fmt[26:24])
      3'd0:       req.lsz = 3'd1;
      3'd1, 3'd2: req.lsz = 3'd2;
      3'd3:       req.lsz = 3'd3;
      3'd4:       req.lsz = 3'd4;
      default: begin
        req.lsz = 3'd1;
        bad_fmt = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ltag_addr_calc.sv
module ltag_addr_calc
  import ltag_pkg::*;
(
  input  logic [IDX_W-1:0]   x,
  input  logic [IDX_W-1:0]   y,
  input  logic [HI_W-1:0]    base_hi,
  input  logic [PITCH_W-1:0] pitch,
  input  logic               tiled,
  input  logic [2:0]         lsz,
  output logic [ADDR_W-1:0]  addr
);
  localparam int LIN_HI_W = ADDR_W - 5;

  logic [12:0]           lin_p;
  logic [IDX_W-1:0]      lin_x;
  logic [IDX_W+4:0]      x_sh;
  logic [LIN_HI_W-1:0]   lin_hi;
  logic [2:0]            tw_sh, th_sh;
  logic [IDX_W-1:0]      til_y, til_x;
  logic [PITCH_W-1:0]    til_p;
  logic [HI_W-1:0]       til_hi;
  logic [TILE_LOG-1:0]   til_lo;

  always_comb begin
    lin_p  = 13'(pitch >> (3'd5 - lsz));
    lin_x  = x >> (3'd5 - lsz);
    x_sh   = {5'b0, x} << lsz;
    lin_hi = LIN_HI_W'(LIN_HI_W'(y) * LIN_HI_W'(lin_p)) + LIN_HI_W'(lin_x)
           + {base_hi, 6'b0};

    tw_sh  = (lsz <= 3'd2) ? 3'd5 : 3'd4;
    case (lsz)
      3'd1:    th_sh = 3'd5;
      3'd4:    th_sh = 3'd3;
      default: th_sh = 3'd4;
    endcase
    til_y  = y >> th_sh;
    til_x  = x >> tw_sh;
    til_p  = pitch >> tw_sh;
    til_hi = HI_W'(HI_W'(til_y) * HI_W'(til_p)) + HI_W'(til_x) + base_hi;

    case (lsz)
      3'd1: til_lo = {y[4]^x[5], x[4]^y[5], y[3]^x[4], x[3]^y[4],
                      y[2], x[2], y[1:0], x[1:0], 1'b0};
      3'd2: til_lo = {y[3]^x[5], x[4]^y[4], y[2]^x[4], x[3]^y[3],
                      y[1], x[2], y[0], x[1:0], 2'b00};
      3'd3: til_lo = {y[3]^x[4], x[3]^y[4], y[2]^x[3], x[2]^y[3],
                      y[1], x[1], y[0], x[0], 3'b000};
      default: til_lo = {y[2]^x[4], x[3]^y[3], y[1]^x[3], x[2]^y[2],
                         y[0], x[1], x[0], 4'b0000};
    endcase

    addr = tiled ? {til_hi, til_lo} : {lin_hi, x_sh[4:0]};
  end
endmodule

// File: rtl/ltag_seq.sv
module ltag_seq
  import ltag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  ltag_req_t         req_in,
  input  logic              req_bad,
  input  logic              out_ready,
  output logic              req_ready,
  output logic              out_valid,
  output ltag_req_t         held,
  output logic [CHAN_W-1:0] step,
  output logic              fmt_err
);
  logic              busy_q, busy_d;
  logic [CHAN_W-1:0] step_q, step_d;
  logic              err_d;
  logic              take, fire, last, load;
  ltag_req_t         held_q;

  always_comb begin
    take   = req_valid & ~busy_q;
    fire   = busy_q & out_ready;
    last   = ~held_q.quad | (step_q == CHAN_W'(3));
    load   = take & ~req_bad;
    busy_d = busy_q;
    step_d = step_q;
    err_d  = take & req_bad;
    if (load) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (fire) begin
      if (last) busy_d = 1'b0;
      else      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      fmt_err <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      step_q  <= step_d;
      fmt_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (load) held_q <= req_in;
  end

  assign req_ready = ~busy_q;
  assign out_valid = busy_q;
  assign held      = held_q;
  assign step      = step_q;

  // R9: no new request is taken while addresses are pending
  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  // R9: a non-final handshake keeps the block busy
  p_busy_mid_quad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && held_q.quad && step_q != 2'd3) |=> out_valid);
  // R7: channels advance by one per accepted address
  p_chan_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && held_q.quad && step_q != 2'd3)
      |=> step_q == $past(step_q) + 2'd1);
  // R11: a reserved format never produces an address
  p_err_no_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !out_valid);
endmodule

// File: rtl/ltag_addr_gen.sv
module ltag_addr_gen
  import ltag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_x,
  input  logic [IDX_W-1:0]  req_y,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [31:0]       req_fmt,
  input  logic              req_is_input,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CHAN_W-1:0] out_chan,
  output logic              fmt_err
);
  ltag_req_t         dec_req, held;
  logic              dec_bad;
  logic [CHAN_W-1:0] step;
  logic [IDX_W-1:0]  cur_x, cur_y;

  ltag_fmt_decode u_dec (
    .x(req_x), .y(req_y), .base(req_base), .fmt(req_fmt),
    .is_input(req_is_input), .req(dec_req), .bad_fmt(dec_bad)
  );

  ltag_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(dec_req),
    .req_bad(dec_bad), .out_ready(out_ready), .req_ready(req_ready),
    .out_valid(out_valid), .held(held), .step(step), .fmt_err(fmt_err)
  );

  // quad corner order: (+1,0) (0,+1) (+1,+1) (0,0)
  always_comb begin
    cur_x = held.x + IDX_W'(held.quad & ~step[0]);
    cur_y = held.y + IDX_W'(held.quad & (step[0] ^ step[1]));
  end

  ltag_addr_calc u_calc (
    .x(cur_x), .y(cur_y), .base_hi(held.base_hi), .pitch(held.pitch),
    .tiled(held.tiled), .lsz(held.lsz), .addr(out_addr)
  );

  assign out_chan = step;

  // R10: a stalled address is held unchanged
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_chan));
  // R2: every element size is at least two bytes
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[0] == 1'b0);
  // R11: the error flag is a single-cycle pulse
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> !fmt_err);
endmodule

// File: tb/sim_ltag_addr_gen.sv
module sim_ltag_addr_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_is_input;
  logic [11:0] req_x, req_y;
  logic [31:0] req_base, req_fmt;
  logic        out_valid, out_ready, fmt_err;
  logic [31:0] out_addr;
  logic [1:0]  out_chan;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ltag_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .req_base(req_base), .req_fmt(req_fmt),
    .req_is_input(req_is_input), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_chan(out_chan), .fmt_err(fmt_err)
  );

  function automatic logic [31:0] mkfmt(input int pitch, input int lay, input int df);
    logic [31:0] f;
    f = '0;
    f[12:2]  = 11'(pitch / 4);
    f[17:16] = 2'(lay);
    f[26:24] = 3'(df);
    return f;
  endfunction

  function automatic logic [31:0] model(input logic [11:0] x, input logic [11:0] y,
                                        input logic [31:0] base, input logic [31:0] fmt);
    int unsigned s, p, b, lw, lh, up;
    logic [31:0] a;
    p = int'(fmt[12:2]) * 4;
    b = base & 32'hFFFF_F800;
    case (fmt[26:24])
      3'd0:       s = 1;
      3'd1, 3'd2: s = 2;
      3'd3:       s = 3;
      default:    s = 4;
    endcase
    if (!fmt[16]) return ((y * (p >> (5 - s))) << 5) + (x << s) + b;
    lw = (s <= 2) ? 5 : 4;
    lh = (s == 1) ? 5 : (s == 4) ? 3 : 4;
    up = (((y >> lh) * (p >> lw)) + (x >> lw)) << 11;
    a  = up + b;
    case (s)
      1: a[10:0] = {y[4]^x[5], x[4]^y[5], y[3]^x[4], x[3]^y[4], y[2], x[2], y[1:0], x[1:0], 1'b0};
      2: a[10:0] = {y[3]^x[5], x[4]^y[4], y[2]^x[4], x[3]^y[3], y[1], x[2], y[0], x[1:0], 2'b0};
      3: a[10:0] = {y[3]^x[4], x[3]^y[4], y[2]^x[3], x[2]^y[3], y[1], x[1], y[0], x[0], 3'b0};
      default: a[10:0] = {y[2]^x[4], x[3]^y[3], y[1]^x[3], x[2]^y[2], y[0], x[1], x[0], 4'b0};
    endcase
    return a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // send one request and consume every address, checking each one
  task automatic run(input string req, input logic [11:0] x, input logic [11:0] y,
                     input logic [31:0] base, input logic [31:0] fmt, input logic inp);
    int n;
    n = (inp && fmt[17]) ? 4 : 1;
    @(negedge clk);
    check("R9 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_x = x; req_y = y; req_base = base;
    req_fmt = fmt; req_is_input = inp; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [11:0] ex, ey;
      ex = (n == 4 && (k == 0 || k == 2)) ? x + 12'd1 : x;
      ey = (n == 4 && (k == 1 || k == 2)) ? y + 12'd1 : y;
      check({req, " valid"}, 32'(out_valid), 32'd1);
      check({req, " addr"}, out_addr, model(ex, ey, base, fmt));
      check({req, " chan R7"}, 32'(out_chan), (n == 4) ? 32'(k) : 32'd0);
      check("R9 ready low while busy", 32'(req_ready), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    check({req, " done R9"}, {30'b0, out_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 fmt_err", 32'(fmt_err), 32'd0);
  endtask

  task automatic t_linear;
    run("R4 lin 2B", 12'd37, 12'd5, 32'h1000_0800, mkfmt(640, 0, 0), 1'b0);
    run("R4 lin 4B", 12'd123, 12'd77, 32'h0040_0000, mkfmt(1024, 0, 1), 1'b0);
    run("R4 lin 4B fp", 12'd4095, 12'd4095, 32'hFFFF_F800, mkfmt(8188, 0, 2), 1'b0);
    run("R4 lin 8B", 12'd1001, 12'd3, 32'h2000_0000, mkfmt(300, 0, 3), 1'b0);
    run("R4 lin 16B R2", 12'd9, 12'd1234, 32'h0000_3000, mkfmt(96, 0, 4), 1'b0);
  endtask

  task automatic t_base_low;
    run("R3 base low ignored", 12'd55, 12'd66, 32'h0012_37FF, mkfmt(512, 0, 1), 1'b0);
    run("R3 base low tiled", 12'd55, 12'd66, 32'h0012_3FFF, mkfmt(512, 1, 1), 1'b0);
  endtask

  task automatic t_tiled;
    run("R5 R6 tile 2B", 12'hABC, 12'h5A5, 32'h0800_0000, mkfmt(2048, 1, 0), 1'b0);
    run("R5 R6 tile 4B", 12'h7FF, 12'h3C3, 32'h0000_0000, mkfmt(4096, 1, 1), 1'b0);
    run("R5 R6 tile 4B b", 12'h03F, 12'h01F, 32'h0010_0800, mkfmt(128, 1, 2), 1'b0);
    run("R5 R6 tile 8B", 12'h99A, 12'hF0F, 32'h4000_0000, mkfmt(1600, 1, 3), 1'b0);
    run("R5 R6 tile 16B", 12'h555, 12'hAAA, 32'h0100_0000, mkfmt(8000, 1, 4), 1'b0);
  endtask

  task automatic t_quad;
    run("R7 quad lin", 12'd20, 12'd30, 32'h0000_8000, mkfmt(256, 2, 2), 1'b1);
    run("R7 quad tile", 12'd31, 12'd15, 32'h0001_0000, mkfmt(512, 3, 0), 1'b1);
    run("R7 quad wrap", 12'hFFF, 12'hFFF, 32'h0000_0000, mkfmt(64, 3, 2), 1'b1);
  endtask

  task automatic t_quad_not_input;
    run("R8 quad non-input lin", 12'd20, 12'd30, 32'h0000_8000, mkfmt(256, 2, 2), 1'b0);
    run("R8 quad non-input tile", 12'd31, 12'd15, 32'h0001_0000, mkfmt(512, 3, 0), 1'b0);
  endtask

  task automatic t_stall;
    logic [31:0] a0;
    @(negedge clk);
    req_valid = 1'b1; req_x = 12'd8; req_y = 12'd9; req_base = 32'h0000_0800;
    req_fmt = mkfmt(256, 2, 0); req_is_input = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    a0 = out_addr;
    check("R10 stall addr pre", a0, model(12'd8, 12'd10, 32'h0000_0800, mkfmt(256, 2, 0)));
    repeat (3) @(negedge clk);
    check("R10 stall valid", 32'(out_valid), 32'd1);
    check("R10 stall addr", out_addr, a0);
    check("R10 stall chan", 32'(out_chan), 32'd1);
    check("R9 ready during stall", 32'(req_ready), 32'd0);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 ready after stall", {30'b0, out_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reserved;
    @(negedge clk);
    req_valid = 1'b1; req_x = 12'd1; req_y = 12'd1; req_base = '0;
    req_fmt = mkfmt(64, 1, 5); req_is_input = 1'b0; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 err pulse", 32'(fmt_err), 32'd1);
    check("R11 no addr", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R11 err clears", 32'(fmt_err), 32'd0);
    check("R11 still no addr", 32'(out_valid), 32'd0);
    check("R11 ready", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_x = '0; req_y = '0; req_base = '0;
    req_fmt = '0; req_is_input = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_linear;
    t_base_low;
    t_tiled;
    t_quad;
    t_quad_not_input;
    t_stall;
    t_reserved;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule